// File: doc/BRIEF.md
# I2C Master Status Flag Unit

This unit sits next to an I2C master bus engine. It turns engine events, FIFO fill levels and the bus pin levels into a status word. From that status word it also produces one interrupt request, one wakeup request and two DMA requests.

Two flags follow FIFO levels continuously:

- The transmit-data flag reports room in the transmit FIFO.
- The receive-data flag reports data waiting in the receive FIFO.

These two flags drive the DMA requests directly.

Seven flags are sticky event flags. Each is set by its own condition and is cleared by writing 1 to its bit. The conditions are:

- end of packet
- STOP sent
- NACK
- arbitration lost
- command FIFO error
- pin-low timeout
- data match

Two busy flags report state only:

- Master busy.
- Bus busy. This flag is held until a STOP is detected, the master is disabled, or an enabled bus-idle timeout expires.

Status bit positions are as follows:

| Bit | Flag |
|-----|------|
| 0 | transmit data |
| 1 | receive data |
| 2 | end of packet |
| 3 | STOP sent |
| 4 | NACK |
| 5 | arbitration lost |
| 6 | command FIFO error |
| 7 | pin-low timeout |
| 8 | data match |
| 9 | master busy |
| 10 | bus busy |

Bits 0 to 8 can interrupt. Each of them has an enable bit at the same index of `irq_en`. The reset is synchronous and active high.

Top module: `i2c_mst_flag_unit`

## Requirements
- R1: `flags[0]` and `tx_dma` are 1 one cycle after a cycle with `tx_fill <= tx_wmark`, and 0 otherwise.
- R2: `flags[1]` and `rx_dma` are 1 one cycle after a cycle with `rx_fill > rx_wmark`, and 0 otherwise.
- R3: A `rstart_sent` pulse sets `flags[2]` only. A `stop_sent` pulse sets both `flags[2]` and `flags[3]`. Each flag is visible on the next cycle.
- R4: With `ack_valid` high, `flags[4]` sets in three cases, where `ack_nack`=1 means a NACK was sampled:
  - address phase, ACK expected, NACK seen;
  - address phase, NACK expected (`ack_expect_nack`=1), ACK seen;
  - `tx_data_phase` high and NACK seen.

  Any other combination leaves `flags[4]` unchanged.
- R5: `flags[5]` sets on `bad_cond`, or when `sda_cmp_valid` is high and `sda_sampled` differs from `sda_driven`.
- R6: `flags[6]` sets when `expect_start` is high and `head_is_start` is low.
- R7: With `plt_en` high, `flags[7]` sets after the selected line has been low for `plt_limit`+1 consecutive cycles. The selected line is SCL when `plt_sel_sda`=0 and SDA when `plt_sel_sda`=1. With `plt_en` low, `flags[7]` never sets.
- R8: `flags[8]` sets when `match_hit` is high and `match_discard` is low.
- R9: Bus busy (`flags[10]`) behaves as follows:
  - It sets the cycle after `bus_act` while `mst_en` is high.
  - It clears after `stop_seen`, or when `mst_en` is low.
  - With `idle_en` high, it also clears after both lines have been high for `idle_limit`+1 cycles.
- R10: `flags[9]` equals `mst_en & mst_busy_in` delayed by one cycle. Neither busy bit can raise `irq` or `wake`.
- R11: Writing 1 to a `clr` bit clears sticky bits 2 to 8. A set condition in the same cycle wins over the clear. `clr` has no effect on bits 0, 1, 9 and 10.
- R12: `irq` and `wake` are each the OR of `flags[8:0] & irq_en`, registered one cycle after the flags.
- R13: While `rst` is high, and on the cycle after a reset edge, `flags`, `irq`, `wake`, `tx_dma` and `rx_dma` are all 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mst_en | input | 1 | Master enabled |
| mst_busy_in | input | 1 | Engine is moving a transfer |
| tx_fill | input | CW | Transmit FIFO fill count |
| tx_wmark | input | CW | Transmit watermark |
| rx_fill | input | CW | Receive FIFO fill count |
| rx_wmark | input | CW | Receive watermark |
| rstart_sent | input | 1 | Pulse: repeated START sent |
| stop_sent | input | 1 | Pulse: STOP sent |
| stop_seen | input | 1 | Pulse: STOP detected on bus |
| ack_valid | input | 1 | Pulse: ACK bit sampled |
| ack_nack | input | 1 | Sampled ACK bit, 1 = NACK |
| ack_expect_nack | input | 1 | NACK was expected in address phase |
| addr_phase | input | 1 | Current byte is an address byte |
| tx_data_phase | input | 1 | Current byte is master-transmitted data |
| bad_cond | input | 1 | Pulse: START/STOP seen at a wrong time |
| sda_cmp_valid | input | 1 | Driven and sampled SDA are comparable |
| sda_driven | input | 1 | SDA value the master drove |
| sda_sampled | input | 1 | SDA value read back |
| expect_start | input | 1 | Master needs a START command next |
| head_is_start | input | 1 | Command FIFO head is a START |
| scl_in | input | 1 | SCL level |
| sda_in | input | 1 | SDA level |
| plt_en | input | 1 | Pin-low timeout enable |
| plt_sel_sda | input | 1 | Time SDA instead of SCL |
| plt_limit | input | TW | Pin-low timeout count |
| idle_en | input | 1 | Bus-idle timeout enable |
| idle_limit | input | TW | Bus-idle timeout count |
| bus_act | input | 1 | Bus activity seen |
| match_hit | input | 1 | Received data equals match value |
| match_discard | input | 1 | Matched data is being discarded |
| irq_en | input | 9 | Interrupt enables for bits 0 to 8 |
| clr | input | 11 | Write-one-to-clear strobes |
| flags | output | 11 | Status flags |
| irq | output | 1 | Interrupt request |
| wake | output | 1 | Wakeup request |
| tx_dma | output | 1 | Transmit DMA request |
| rx_dma | output | 1 | Receive DMA request |

## Verification
All flags are due one clock edge after the input cycle that causes them. `irq` and `wake` are due one edge later still, because they are computed from the registered flags.

Timeouts take longer. The pin-low flag appears on the (`plt_limit`+1)-th edge of continuous low level. Bus busy drops on the (`idle_limit`+1)-th edge of continuous idle level.

The checks drive inputs just after an edge and sample just after the edge at which each result is due. Each timeout is also checked one edge early, to show that the flag has not yet appeared.

// File: rtl/i2c_flag_pkg.sv
package i2c_flag_pkg;
  localparam int NFLAG = 11;
  localparam int NIRQ  = 9;
  localparam int F_TXD  = 0;
  localparam int F_RXD  = 1;
  localparam int F_EPK  = 2;
  localparam int F_STP  = 3;
  localparam int F_NAK  = 4;
  localparam int F_ARB  = 5;
  localparam int F_FER  = 6;
  localparam int F_PLT  = 7;
  localparam int F_DMT  = 8;
  localparam int F_MBSY = 9;
  localparam int F_BBSY = 10;
  localparam logic [NFLAG-1:0] STICKY_MASK = 11'b001_1111_1100;
endpackage

// File: rtl/i2c_flag_tmr.sv
module i2c_flag_tmr #(
  parameter int W = 12
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         active,
  input  logic [W-1:0] limit,
  output logic         hit
);
  localparam logic [W-1:0] CNT_MAX = '1;
  logic [W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || !active) cnt <= '0;
    else if (cnt != CNT_MAX) cnt <= cnt + 1'b1;
  end

  assign hit = active && (cnt == limit);
endmodule

// File: rtl/i2c_flag_events.sv
module i2c_flag_events
  import i2c_flag_pkg::*;
(
  input  logic             rstart_sent,
  input  logic             stop_sent,
  input  logic             ack_valid,
  input  logic             ack_nack,
  input  logic             ack_expect_nack,
  input  logic             addr_phase,
  input  logic             tx_data_phase,
  input  logic             bad_cond,
  input  logic             sda_cmp_valid,
  input  logic             sda_driven,
  input  logic             sda_sampled,
  input  logic             expect_start,
  input  logic             head_is_start,
  input  logic             plt_hit,
  input  logic             match_hit,
  input  logic             match_discard,
  output logic [NFLAG-1:0] ev_set
);
  logic nak_addr, nak_data;

  always_comb begin
    nak_addr = addr_phase && (ack_nack != ack_expect_nack);
    nak_data = !addr_phase && tx_data_phase && ack_nack;
    ev_set        = '0;
    ev_set[F_EPK] = rstart_sent || stop_sent;
    ev_set[F_STP] = stop_sent;
    ev_set[F_NAK] = ack_valid && (nak_addr || nak_data);
    ev_set[F_ARB] = bad_cond || (sda_cmp_valid && (sda_driven != sda_sampled));
    ev_set[F_FER] = expect_start && !head_is_start;
    ev_set[F_PLT] = plt_hit;
    ev_set[F_DMT] = match_hit && !match_discard;
  end
endmodule

// File: rtl/i2c_flag_bbusy.sv
module i2c_flag_bbusy #(
  parameter int TW = 12
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          mst_en,
  input  logic          bus_act,
  input  logic          stop_seen,
  input  logic          scl_in,
  input  logic          sda_in,
  input  logic          idle_en,
  input  logic [TW-1:0] idle_limit,
  input  logic          busy_q,
  output logic          busy_d
);
  logic idle_hit;

  i2c_flag_tmr #(.W(TW)) u_idle (
    .clk    (clk),
    .rst    (rst),
    .active (idle_en && busy_q && scl_in && sda_in),
    .limit  (idle_limit),
    .hit    (idle_hit)
  );

  always_comb begin
    if (!mst_en)                    busy_d = 1'b0;
    else if (stop_seen || idle_hit) busy_d = 1'b0;
    else if (bus_act)               busy_d = 1'b1;
    else                            busy_d = busy_q;
  end
endmodule

// File: rtl/i2c_mst_flag_unit.sv
module i2c_mst_flag_unit
  import i2c_flag_pkg::*;
#(
  parameter int FIFO_DEPTH = 8,
  parameter int TW         = 12,
  localparam int CW        = $clog2(FIFO_DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             mst_en,
  input  logic             mst_busy_in,
  input  logic [CW-1:0]    tx_fill,
  input  logic [CW-1:0]    tx_wmark,
  input  logic [CW-1:0]    rx_fill,
  input  logic [CW-1:0]    rx_wmark,
  input  logic             rstart_sent,
  input  logic             stop_sent,
  input  logic             stop_seen,
  input  logic             ack_valid,
  input  logic             ack_nack,
  input  logic             ack_expect_nack,
  input  logic             addr_phase,
  input  logic             tx_data_phase,
  input  logic             bad_cond,
  input  logic             sda_cmp_valid,
  input  logic             sda_driven,
  input  logic             sda_sampled,
  input  logic             expect_start,
  input  logic             head_is_start,
  input  logic             scl_in,
  input  logic             sda_in,
  input  logic             plt_en,
  input  logic             plt_sel_sda,
  input  logic [TW-1:0]    plt_limit,
  input  logic             idle_en,
  input  logic [TW-1:0]    idle_limit,
  input  logic             bus_act,
  input  logic             match_hit,
  input  logic             match_discard,
  input  logic [NIRQ-1:0]  irq_en,
  input  logic [NFLAG-1:0] clr,
  output logic [NFLAG-1:0] flags,
  output logic             irq,
  output logic             wake,
  output logic             tx_dma,
  output logic             rx_dma
);
  logic [NFLAG-1:0] flag_q, flag_d, ev_set, lvl;
  logic             plt_hit, bbusy_d, req_any, irq_q, wake_q;

  i2c_flag_tmr #(.W(TW)) u_plt (
    .clk    (clk),
    .rst    (rst),
    .active (plt_en && !(plt_sel_sda ? sda_in : scl_in)),
    .limit  (plt_limit),
    .hit    (plt_hit)
  );

  i2c_flag_events u_ev (
    .rstart_sent     (rstart_sent),
    .stop_sent       (stop_sent),
    .ack_valid       (ack_valid),
    .ack_nack        (ack_nack),
    .ack_expect_nack (ack_expect_nack),
    .addr_phase      (addr_phase),
    .tx_data_phase   (tx_data_phase),
    .bad_cond        (bad_cond),
    .sda_cmp_valid   (sda_cmp_valid),
    .sda_driven      (sda_driven),
    .sda_sampled     (sda_sampled),
    .expect_start    (expect_start),
    .head_is_start   (head_is_start),
    .plt_hit         (plt_hit),
    .match_hit       (match_hit),
    .match_discard   (match_discard),
    .ev_set          (ev_set)
  );

  i2c_flag_bbusy #(.TW(TW)) u_bb (
    .clk        (clk),
    .rst        (rst),
    .mst_en     (mst_en),
    .bus_act    (bus_act),
    .stop_seen  (stop_seen),
    .scl_in     (scl_in),
    .sda_in     (sda_in),
    .idle_en    (idle_en),
    .idle_limit (idle_limit),
    .busy_q     (flag_q[F_BBSY]),
    .busy_d     (bbusy_d)
  );

  always_comb begin
    lvl         = '0;
    lvl[F_TXD]  = (tx_fill <= tx_wmark);
    lvl[F_RXD]  = (rx_fill > rx_wmark);
    lvl[F_MBSY] = mst_en && mst_busy_in;
    lvl[F_BBSY] = bbusy_d;
    flag_d      = lvl | (ev_set & STICKY_MASK) | (flag_q & ~clr & STICKY_MASK);
    req_any     = |(flag_q[NIRQ-1:0] & irq_en);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      flag_q <= '0;
      irq_q  <= 1'b0;
      wake_q <= 1'b0;
    end else begin
      flag_q <= flag_d;
      irq_q  <= req_any;
      wake_q <= req_any;
    end
  end

  assign flags  = flag_q;
  assign irq    = irq_q;
  assign wake   = wake_q;
  assign tx_dma = flag_q[F_TXD];
  assign rx_dma = flag_q[F_RXD];
endmodule

// File: rtl/i2c_flag_chk.sv
module i2c_flag_chk
  import i2c_flag_pkg::*;
#(
  parameter int CW = 4
) (
  input logic             clk,
  input logic             rst,
  input logic [CW-1:0]    tx_fill,
  input logic [CW-1:0]    tx_wmark,
  input logic [CW-1:0]    rx_fill,
  input logic [CW-1:0]    rx_wmark,
  input logic             stop_sent,
  input logic             expect_start,
  input logic             head_is_start,
  input logic             sda_cmp_valid,
  input logic             sda_driven,
  input logic             sda_sampled,
  input logic             match_hit,
  input logic             match_discard,
  input logic [NIRQ-1:0]  irq_en,
  input logic [NFLAG-1:0] clr,
  input logic [NFLAG-1:0] flags,
  input logic             irq,
  input logic             wake
);
  logic pv = 1'b0;
  always_ff @(posedge clk) pv <= 1'b1;

  AST_TXD_LEVEL: assert property (@(posedge clk) disable iff (rst)
    pv |=> flags[F_TXD] == $past(tx_fill <= tx_wmark)); // R1
  AST_RXD_LEVEL: assert property (@(posedge clk) disable iff (rst)
    pv |=> flags[F_RXD] == $past(rx_fill > rx_wmark)); // R2
  AST_STOP_SETS: assert property (@(posedge clk) disable iff (rst)
    stop_sent |=> flags[F_EPK] && flags[F_STP]); // R3
  AST_ARB_MISMATCH: assert property (@(posedge clk) disable iff (rst)
    sda_cmp_valid && (sda_driven != sda_sampled) |=> flags[F_ARB]); // R5
  AST_FIFO_ERR: assert property (@(posedge clk) disable iff (rst)
    expect_start && !head_is_start |=> flags[F_FER]); // R6
  AST_MATCH_SET: assert property (@(posedge clk) disable iff (rst)
    match_hit && !match_discard |=> flags[F_DMT]); // R8
  AST_BUSY_NO_IRQ: assert property (@(posedge clk) disable iff (rst)
    pv && ((flags[NIRQ-1:0] & irq_en) == '0) |=> !irq && !wake); // R10
  AST_NAK_HOLD: assert property (@(posedge clk) disable iff (rst)
    flags[F_NAK] && !clr[F_NAK] |=> flags[F_NAK]); // R11
  AST_IRQ_DELAY: assert property (@(posedge clk) disable iff (rst)
    pv |=> irq == $past(|(flags[NIRQ-1:0] & irq_en))); // R12
endmodule

bind i2c_mst_flag_unit i2c_flag_chk #(.CW(CW)) u_chk (
  .clk           (clk),
  .rst           (rst),
  .tx_fill       (tx_fill),
  .tx_wmark      (tx_wmark),
  .rx_fill       (rx_fill),
  .rx_wmark      (rx_wmark),
  .stop_sent     (stop_sent),
  .expect_start  (expect_start),
  .head_is_start (head_is_start),
  .sda_cmp_valid (sda_cmp_valid),
  .sda_driven    (sda_driven),
  .sda_sampled   (sda_sampled),
  .match_hit     (match_hit),
  .match_discard (match_discard),
  .irq_en        (irq_en),
  .clr           (clr),
  .flags         (flags),
  .irq           (irq),
  .wake          (wake)
);

// File: tb/i2c_mst_flag_unit_bench.sv
module i2c_mst_flag_unit_bench;
  localparam int CW = 4;
  localparam int TW = 12;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rst, mst_en, mst_busy_in;
  logic [CW-1:0] tx_fill, tx_wmark, rx_fill, rx_wmark;
  logic rstart_sent, stop_sent, stop_seen, ack_valid, ack_nack, ack_expect_nack;
  logic addr_phase, tx_data_phase, bad_cond, sda_cmp_valid, sda_driven, sda_sampled;
  logic expect_start, head_is_start, scl_in, sda_in, plt_en, plt_sel_sda;
  logic [TW-1:0] plt_limit, idle_limit;
  logic idle_en, bus_act, match_hit, match_discard;
  logic [8:0]  irq_en;
  logic [10:0] clr, flags;
  logic irq, wake, tx_dma, rx_dma;

  i2c_mst_flag_unit #(.FIFO_DEPTH(8), .TW(TW)) u_i2c_mst_flag_unit (.*);

  int checks = 0, failures = 0, cyc = 0;
  bit done = 1'b0;

  // {tx_fill, tx_wmark, rx_fill, rx_wmark, exp_txd, exp_rxd}
  localparam logic [17:0] VEC [8] = '{
    {4'd0, 4'd0, 4'd0, 4'd0, 1'b1, 1'b0},
    {4'd3, 4'd3, 4'd4, 4'd3, 1'b1, 1'b1},
    {4'd4, 4'd3, 4'd3, 4'd3, 1'b0, 1'b0},
    {4'd8, 4'd7, 4'd8, 4'd7, 1'b0, 1'b1},
    {4'd0, 4'd7, 4'd1, 4'd0, 1'b1, 1'b1},
    {4'd5, 4'd6, 4'd6, 4'd6, 1'b1, 1'b0},
    {4'd7, 4'd7, 4'd2, 4'd5, 1'b1, 1'b0},
    {4'd8, 4'd8, 4'd8, 4'd0, 1'b1, 1'b1}
  };

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic clear_all();
    clr = '1;
    step();
    clr = '0;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000 && !done) begin
      done = 1'b1;
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    rst = 1; mst_en = 0; mst_busy_in = 0;
    tx_fill = 8; tx_wmark = 0; rx_fill = 0; rx_wmark = 0;
    rstart_sent = 0; stop_sent = 0; stop_seen = 0; ack_valid = 0; ack_nack = 0;
    ack_expect_nack = 0; addr_phase = 0; tx_data_phase = 0; bad_cond = 0;
    sda_cmp_valid = 0; sda_driven = 0; sda_sampled = 0; expect_start = 0;
    head_is_start = 0; scl_in = 1; sda_in = 1; plt_en = 0; plt_sel_sda = 0;
    plt_limit = 3; idle_en = 0; idle_limit = 2; bus_act = 0; match_hit = 0;
    match_discard = 0; irq_en = '0; clr = '0;

    // R13: outputs held low while reset is high, even with events driven
    stop_sent = 1; tx_fill = 0;
    step(); step();
    chk("R13", "flags in reset", flags, 0);
    chk("R13", "irq/wake/dma in reset", {irq, wake, tx_dma, rx_dma}, 0);
    stop_sent = 0; tx_fill = 8;
    rst = 0;
    step();
    chk("R13", "flags after reset", flags, 0);

    // R1, R2: vector table for level flags and DMA requests
    for (int i = 0; i < 8; i++) begin
      {tx_fill, tx_wmark, rx_fill, rx_wmark} = VEC[i][17:2];
      step();
      chk("R1", $sformatf("txd vec %0d", i), {flags[0], tx_dma}, {2{VEC[i][1]}});
      chk("R2", $sformatf("rxd vec %0d", i), {flags[1], rx_dma}, {2{VEC[i][0]}});
    end
    tx_fill = 8; tx_wmark = 0; rx_fill = 0; rx_wmark = 0;
    step();

    // R3: repeated START vs STOP
    rstart_sent = 1; step(); rstart_sent = 0;
    chk("R3", "rstart sets end-packet only", flags[3:2], 2'b01);
    clear_all();
    chk("R3", "cleared", flags[3:2], 2'b00);
    stop_sent = 1; step(); stop_sent = 0;
    chk("R3", "stop sets both", flags[3:2], 2'b11);
    clear_all();

    // R4: NACK cases (ack_nack=1 means NACK)
    ack_valid = 1; addr_phase = 1; ack_expect_nack = 0; ack_nack = 1; step();
    chk("R4", "addr NACK when ACK expected", flags[4], 1);
    ack_valid = 0; clear_all();
    ack_valid = 1; addr_phase = 1; ack_expect_nack = 1; ack_nack = 0; step();
    chk("R4", "addr ACK when NACK expected", flags[4], 1);
    ack_valid = 0; clear_all();
    ack_valid = 1; addr_phase = 0; ack_expect_nack = 0; tx_data_phase = 1; ack_nack = 1; step();
    chk("R4", "tx data NACK", flags[4], 1);
    ack_valid = 0; clear_all();
    ack_valid = 1; addr_phase = 1; ack_expect_nack = 0; tx_data_phase = 0; ack_nack = 0; step();
    chk("R4", "addr ACK as expected no set", flags[4], 0);
    addr_phase = 0; ack_nack = 1; step();
    chk("R4", "receive data NACK no set", flags[4], 0);
    ack_valid = 0; ack_nack = 0;

    // R5: arbitration loss
    bad_cond = 1; step(); bad_cond = 0;
    chk("R5", "mistimed condition", flags[5], 1);
    clear_all();
    sda_cmp_valid = 1; sda_driven = 1; sda_sampled = 0; step();
    chk("R5", "sda mismatch", flags[5], 1);
    sda_sampled = 1; clear_all();
    step();
    chk("R5", "sda equal no set", flags[5], 0);
    sda_cmp_valid = 0;

    // R6: command FIFO error
    expect_start = 1; head_is_start = 1; step();
    chk("R6", "head is start no set", flags[6], 0);
    head_is_start = 0; step(); expect_start = 0;
    chk("R6", "head not start", flags[6], 1);
    clear_all();

    // R7: pin-low timeout, limit 3 -> set on 4th low edge
    plt_en = 1; scl_in = 0;
    step(); step(); step();
    chk("R7", "scl low 3 cycles", flags[7], 0);
    step();
    chk("R7", "scl low 4 cycles", flags[7], 1);
    scl_in = 1; clear_all();
    plt_en = 0; scl_in = 0;
    for (int k = 0; k < 8; k++) step();
    chk("R7", "disabled no set", flags[7], 0);
    scl_in = 1; plt_en = 1; plt_sel_sda = 1; sda_in = 0;
    step(); step(); step(); step();
    chk("R7", "sda selected", flags[7], 1);
    sda_in = 1; plt_en = 0; plt_sel_sda = 0; clear_all();

    // R8: data match
    match_hit = 1; match_discard = 1; step();
    chk("R8", "discarded no set", flags[8], 0);
    match_discard = 0; step(); match_hit = 0;
    chk("R8", "match", flags[8], 1);
    clear_all();

    // R9: bus busy set, STOP clear, idle timeout clear
    mst_en = 1; bus_act = 1; step(); bus_act = 0;
    chk("R9", "busy set", flags[10], 1);
    step();
    chk("R9", "busy held", flags[10], 1);
    stop_seen = 1; step(); stop_seen = 0;
    chk("R9", "stop clears", flags[10], 0);
    idle_en = 1; scl_in = 0; bus_act = 1; step(); bus_act = 0;
    scl_in = 1;
    step(); step();
    chk("R9", "idle 2 cycles still busy", flags[10], 1);
    step();
    chk("R9", "idle timeout clears", flags[10], 0);
    idle_en = 0;

    // R10: master busy, busy bits cannot interrupt
    irq_en = '1; mst_busy_in = 1; bus_act = 1; step(); bus_act = 0;
    chk("R10", "busy bits", flags[10:9], 2'b11);
    step();
    chk("R10", "no irq/wake from busy", {irq, wake}, 2'b00);
    mst_busy_in = 0; stop_seen = 1; step(); stop_seen = 0; mst_en = 0;
    chk("R10", "master busy follows", flags[9], 0);
    irq_en = '0;

    // R11: set wins over clear; level bits ignore clear
    ack_valid = 1; addr_phase = 1; ack_nack = 1; step();
    clr = 11'b000_0001_0000; step();
    chk("R11", "set wins over clear", flags[4], 1);
    ack_valid = 0; addr_phase = 0; ack_nack = 0; step(); clr = '0;
    chk("R11", "clear works", flags[4], 0);
    tx_fill = 0; step();
    clr = 11'b000_0000_0001; step(); clr = '0;
    chk("R11", "clear ignored on txd", flags[0], 1);
    tx_fill = 8; step();

    // R12: irq/wake one cycle after flag, gated by enable
    irq_en = 9'b0_0001_0000;
    match_hit = 1; step(); match_hit = 0;
    step();
    chk("R12", "disabled flag no irq", {irq, wake}, 2'b00);
    ack_valid = 1; addr_phase = 1; ack_nack = 1; step();
    ack_valid = 0; addr_phase = 0; ack_nack = 0;
    chk("R12", "irq not yet", irq, 0);
    step();
    chk("R12", "irq and wake", {irq, wake}, 2'b11);
    irq_en = '0; step();
    chk("R12", "irq drops with enable", {irq, wake}, 2'b00);
    clear_all();

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule